// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block picks the handshake that endpoint 0 of a USB device returns during a control read transfer. Each cycle it may be offered one finished transaction from the packet decoder: the token type, whether the data packet carried DATA1, whether that packet was empty, and whether its CRC checked good. It weighs this against three control bits held by firmware: FIFO enable, the endpoint-halt flag and a forced-stall command. It then answers with ACK, NAK, STALL or silence, and pulses an interrupt strobe where one is due.

Internally it follows the transfer from setup through the data stage to the status stage. Once it has sent STALL it keeps sending STALL until a fresh SETUP arrives. The host may give up on a transfer at any point by sending a new SETUP, and the responder then restarts from any stage. The forced-stall command overrides the handshake but leaves the visible halted flag untouched. In the status stage a non-empty payload is acknowledged but never stored, and a payload with the wrong data PID is stalled. Packet decoding and FIFO storage sit outside this block.

Every output is registered and changes on the clock edge that samples the transaction. Encodings used on the ports: handshake 0 = none, 1 = ACK, 2 = NAK, 3 = STALL. Token 0 = SETUP, 1 = IN, 2 = OUT, 3 = host ACK of an IN data packet. Stage 0 = idle, 1 = data, 2 = status.

Top module: `cep0_hs_responder`

## Requirements
- R1: After reset hs_code is 0, every strobe is low, xfer_stage is 0 (idle) and ep_halted is 0.
- R2: A transaction with pkt_crc_ok low gets hs_code 0, raises no strobe and changes neither the stage nor the sticky stall.
- R3: A good SETUP token (0) with DATA0 (pkt_data1 = 0) is answered with ACK (1) and irq_setup in any stage. It moves the stage to data (1) and clears the sticky stall. A SETUP with DATA1 gets no response and changes nothing.
- R4: An IN token (1) in the data stage gets STALL (3) if stall_cmd, ep_halted or the sticky stall is set. Otherwise it gets NAK (2) when fifo_en is low, and ACK (1) in the remaining case.
- R5: Once STALL has been returned, every IN or OUT in the data or status stage gets STALL until a good DATA0 SETUP arrives.
- R6: ep_halted is set by halt_set and cleared by halt_clr, with set winning when both are high. It holds otherwise, and stall_cmd never changes it.
- R7: irq_tx_done pulses one cycle after a host-ACK token (3) that follows an ACKed data-stage IN. A host ACK with no such IN outstanding, or after an IN that got NAK or STALL, raises nothing.
- R8: An OUT token (2) in the data or status stage puts the transfer in the status stage, where ep_halted is ignored. stall_cmd gives STALL. DATA0 gives STALL with irq_rx_done. Otherwise fifo_en low gives NAK, and fifo_en high gives ACK with irq_rx_done and a return to idle.
- R9: rx_wr_en stays low for every status-stage OUT, including an ACKed non-empty one (pkt_empty = 0).
- R10: IN and OUT tokens in the idle stage get no response and no strobe.
- R11: An IN token in the status stage gets STALL, which becomes sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A finished transaction is offered this cycle |
| pkt_token | input | 2 | Token type: 0 SETUP, 1 IN, 2 OUT, 3 host ACK |
| pkt_data1 | input | 1 | Data packet carried DATA1 (0 = DATA0) |
| pkt_empty | input | 1 | Data packet had zero length |
| pkt_crc_ok | input | 1 | Packet passed its CRC check |
| fifo_en | input | 1 | Firmware has the endpoint FIFO ready |
| halt_set | input | 1 | Pulse that sets the halted flag |
| halt_clr | input | 1 | Pulse that clears the halted flag |
| stall_cmd | input | 1 | Forced-stall command |
| hs_code | output | 2 | Handshake: 0 none, 1 ACK, 2 NAK, 3 STALL |
| rx_wr_en | output | 1 | Write strobe toward the receive FIFO |
| irq_setup | output | 1 | SETUP accepted strobe |
| irq_tx_done | output | 1 | IN data acknowledged by host strobe |
| irq_rx_done | output | 1 | Status-stage OUT handled strobe |
| ep_halted | output | 1 | Visible halted flag |
| xfer_stage | output | 2 | Stage: 0 idle, 1 data, 2 status |

## Verification
Any wrong internal state surfaces at the ports on the clock edge that samples the next transaction. A sticky stall that was lost shows up as NAK or ACK where STALL was due. A stall that was never cleared shows up as STALL after a good SETUP. A stale transmit-pending bit shows up as a spurious irq_tx_done on a later host ACK. xfer_stage is on the port list, so a wrong stage is visible on the same edge that changed it, and the bench compares every output against a behavioural model after every clock.

// File: rtl/cep0_hs_pkg.sv
package cep0_hs_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_IN    = 2'd1,
        TK_OUT   = 2'd2,
        TK_HACK  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_STATUS = 2'd2
    } stage_e;

    typedef struct packed {
        tok_e tok;
        logic data1;
        logic empty;
        logic crc_ok;
    } pkt_s;

    typedef struct packed {
        logic fifo_en;
        logic halted;
        logic stall_cmd;
    } ctl_s;

    typedef struct packed {
        stage_e stage;
        logic   stall_lat;
        logic   tx_pend;
    } ctx_s;

    typedef struct packed {
        hs_e  hs;
        ctx_s nxt;
        logic irq_setup;
        logic irq_tx;
        logic irq_rx;
        logic rx_wr;
    } dec_s;

    // Shared priority: forced stall, then not-ready, then accept.
    function automatic hs_e hs_prio(input logic force_stall, input logic ready);
        if (force_stall)
            return HS_STALL;
        else if (!ready)
            return HS_NAK;
        else
            return HS_ACK;
    endfunction

endpackage

// File: rtl/cep0_hs_decide.sv
module cep0_hs_decide
    import cep0_hs_pkg::*;
(
    input  logic pkt_valid,
    input  pkt_s pkt,
    input  ctl_s ctl,
    input  ctx_s ctx,
    output dec_s dec
);

    always_comb begin
        dec       = '0;
        dec.hs    = HS_NONE;
        dec.nxt   = ctx;
        if (pkt_valid && pkt.crc_ok) begin
            unique case (pkt.tok)
                TK_SETUP: begin
                    if (!pkt.data1) begin
                        dec.hs            = HS_ACK;
                        dec.irq_setup     = 1'b1;
                        dec.nxt.stage     = ST_DATA;
                        dec.nxt.stall_lat = 1'b0;
                        dec.nxt.tx_pend   = 1'b0;
                    end
                end
                TK_IN: begin
                    case (ctx.stage)
                        ST_DATA: begin
                            dec.hs = hs_prio(ctl.stall_cmd | ctl.halted | ctx.stall_lat,
                                             ctl.fifo_en);
                            dec.nxt.tx_pend = (dec.hs == HS_ACK);
                        end
                        ST_STATUS: dec.hs = HS_STALL;
                        default: ;
                    endcase
                end
                TK_OUT: begin
                    if (ctx.stage != ST_IDLE) begin
                        dec.nxt.stage   = ST_STATUS;
                        dec.nxt.tx_pend = 1'b0;
                        if (ctl.stall_cmd || ctx.stall_lat) begin
                            dec.hs = HS_STALL;
                        end else if (!pkt.data1) begin
                            dec.hs     = HS_STALL;
                            dec.irq_rx = 1'b1;
                        end else begin
                            // halted flag plays no part in the status stage
                            dec.hs = hs_prio(1'b0, ctl.fifo_en);
                            if (dec.hs == HS_ACK) begin
                                dec.irq_rx    = 1'b1;
                                dec.nxt.stage = ST_IDLE;
                            end
                        end
                        // status payload is acknowledged but never stored
                        dec.rx_wr = 1'b0;
                    end
                end
                TK_HACK: begin
                    if (ctx.tx_pend) begin
                        dec.irq_tx      = 1'b1;
                        dec.nxt.tx_pend = 1'b0;
                    end
                end
            endcase
            if (dec.hs == HS_STALL)
                dec.nxt.stall_lat = 1'b1;
        end
    end

endmodule

// File: rtl/cep0_ctx_reg.sv
module cep0_ctx_reg
    import cep0_hs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctx_s ctx_nxt,
    input  logic halt_set,
    input  logic halt_clr,
    output ctx_s ctx,
    output logic halted
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.stage     <= ST_IDLE;
            ctx.stall_lat <= 1'b0;
            ctx.tx_pend   <= 1'b0;
            halted        <= 1'b0;
        end else begin
            ctx <= ctx_nxt;
            if (halt_set)
                halted <= 1'b1;
            else if (halt_clr)
                halted <= 1'b0;
        end
    end

    // R6: halted flag moves only on its own set/clear pulses
    a_r6_halt_hold: assert property (@(posedge clk) disable iff (rst)
        (!halt_set && !halt_clr) |=> $stable(halted));

    a_r6_halt_set_wins: assert property (@(posedge clk) disable iff (rst)
        halt_set |=> halted);

    // sticky stall drops only through a stage reset to data
    a_r5_lat_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(ctx.stall_lat) |-> ctx.stage == ST_DATA);

endmodule

// File: rtl/cep0_hs_responder.sv
module cep0_hs_responder
    import cep0_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pkt_valid,
    input  logic [1:0] pkt_token,
    input  logic       pkt_data1,
    input  logic       pkt_empty,
    input  logic       pkt_crc_ok,
    input  logic       fifo_en,
    input  logic       halt_set,
    input  logic       halt_clr,
    input  logic       stall_cmd,
    output logic [1:0] hs_code,
    output logic       rx_wr_en,
    output logic       irq_setup,
    output logic       irq_tx_done,
    output logic       irq_rx_done,
    output logic       ep_halted,
    output logic [1:0] xfer_stage
);

    pkt_s pkt;
    ctl_s ctl;
    ctx_s ctx;
    dec_s dec;

    always_comb begin
        pkt.tok    = tok_e'(pkt_token);
        pkt.data1  = pkt_data1;
        pkt.empty  = pkt_empty;
        pkt.crc_ok = pkt_crc_ok;
        ctl.fifo_en   = fifo_en;
        ctl.halted    = ep_halted;
        ctl.stall_cmd = stall_cmd;
    end

    cep0_hs_decide u_decide (
        .pkt_valid (pkt_valid),
        .pkt       (pkt),
        .ctl       (ctl),
        .ctx       (ctx),
        .dec       (dec)
    );

    cep0_ctx_reg u_ctx (
        .clk      (clk),
        .rst      (rst),
        .ctx_nxt  (dec.nxt),
        .halt_set (halt_set),
        .halt_clr (halt_clr),
        .ctx      (ctx),
        .halted   (ep_halted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_code     <= HS_NONE;
            rx_wr_en    <= 1'b0;
            irq_setup   <= 1'b0;
            irq_tx_done <= 1'b0;
            irq_rx_done <= 1'b0;
        end else begin
            hs_code     <= dec.hs;
            rx_wr_en    <= dec.rx_wr;
            irq_setup   <= dec.irq_setup;
            irq_tx_done <= dec.irq_tx;
            irq_rx_done <= dec.irq_rx;
        end
    end

    assign xfer_stage = ctx.stage;

    // R2: corrupted packets stay silent
    a_r2_crc_silent: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_crc_ok) |=>
            (hs_code == HS_NONE && !irq_setup && !irq_tx_done && !irq_rx_done));

    // R3: good DATA0 SETUP is always accepted and restarts the data stage
    a_r3_setup_ack: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_crc_ok && pkt_token == TK_SETUP && !pkt_data1) |=>
            (hs_code == HS_ACK && irq_setup && xfer_stage == ST_DATA));

    // R5: sticky stall answers every IN/OUT in an active transfer
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_crc_ok && ctx.stall_lat && ctx.stage != ST_IDLE &&
         (pkt_token == TK_IN || pkt_token == TK_OUT)) |=> hs_code == HS_STALL);

    // R7: transmit-done only follows a host ACK token
    a_r7_tx_after_hack: assert property (@(posedge clk) disable iff (rst)
        irq_tx_done |-> $past(pkt_valid && pkt_token == TK_HACK));

    // R9: status-stage OUT never writes the receive FIFO
    a_r9_no_store: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_token == TK_OUT) |=> !rx_wr_en);

    // R10: idle stage ignores IN and OUT
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && ctx.stage == ST_IDLE &&
         (pkt_token == TK_IN || pkt_token == TK_OUT)) |=> hs_code == HS_NONE);

    a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_setup, irq_tx_done, irq_rx_done}));

endmodule

// File: tb/cep0_hs_responder_bench.sv
module cep0_hs_responder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pkt_valid = 1'b0;
    logic [1:0] pkt_token = 2'd0;
    logic       pkt_data1 = 1'b0;
    logic       pkt_empty = 1'b1;
    logic       pkt_crc_ok = 1'b1;
    logic       fifo_en = 1'b0;
    logic       halt_set = 1'b0;
    logic       halt_clr = 1'b0;
    logic       stall_cmd = 1'b0;
    logic [1:0] hs_code;
    logic       rx_wr_en, irq_setup, irq_tx_done, irq_rx_done, ep_halted;
    logic [1:0] xfer_stage;

    cep0_hs_responder u_cep0_hs_responder (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_token(pkt_token),
        .pkt_data1(pkt_data1), .pkt_empty(pkt_empty), .pkt_crc_ok(pkt_crc_ok),
        .fifo_en(fifo_en), .halt_set(halt_set), .halt_clr(halt_clr),
        .stall_cmd(stall_cmd), .hs_code(hs_code), .rx_wr_en(rx_wr_en),
        .irq_setup(irq_setup), .irq_tx_done(irq_tx_done), .irq_rx_done(irq_rx_done),
        .ep_halted(ep_halted), .xfer_stage(xfer_stage)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference model
    int m_stage = 0;
    bit m_lat = 0, m_pend = 0, m_halt = 0;
    int e_code = 0;
    bit e_setup = 0, e_tx = 0, e_rx = 0, e_wr = 0;

    always @(posedge clk) begin
        cycles++;
        e_code = 0; e_setup = 0; e_tx = 0; e_rx = 0; e_wr = 0;
        if (rst) begin
            m_stage = 0; m_lat = 0; m_pend = 0; m_halt = 0;
        end else begin
            if (pkt_valid && pkt_crc_ok) begin
                if (pkt_token == 2'd0) begin
                    if (!pkt_data1) begin
                        e_code = 1; e_setup = 1; m_stage = 1; m_lat = 0; m_pend = 0;
                    end
                end else if (pkt_token == 2'd1) begin
                    if (m_stage == 2) begin
                        e_code = 3; m_lat = 1;
                    end else if (m_stage == 1) begin
                        if (stall_cmd || m_halt || m_lat) begin
                            e_code = 3; m_lat = 1;
                        end else if (!fifo_en)
                            e_code = 2;
                        else
                            e_code = 1;
                        m_pend = (e_code == 1);
                    end
                end else if (pkt_token == 2'd2) begin
                    if (m_stage != 0) begin
                        m_stage = 2; m_pend = 0;
                        if (stall_cmd || m_lat) begin
                            e_code = 3; m_lat = 1;
                        end else if (!pkt_data1) begin
                            e_code = 3; m_lat = 1; e_rx = 1;
                        end else if (!fifo_en)
                            e_code = 2;
                        else begin
                            e_code = 1; e_rx = 1; m_stage = 0;
                        end
                    end
                end else begin
                    if (m_pend) begin
                        e_tx = 1; m_pend = 0;
                    end
                end
            end
            if (halt_set) m_halt = 1;
            else if (halt_clr) m_halt = 0;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        logic [7:0] act, exp;
        act = {hs_code, rx_wr_en, irq_setup, irq_tx_done, irq_rx_done, ep_halted, 1'b0};
        exp = {e_code[1:0], e_wr, e_setup, e_tx, e_rx, m_halt, 1'b0};
        checks++;
        if (act !== exp || xfer_stage !== m_stage[1:0]) begin
            errors++;
            $display("FAIL %s cycle %0d: actual hs/wr/setup/tx/rx/halt=%b stage=%0d expected %b stage=%0d",
                     cur_req, cycles, act[7:1], xfer_stage, exp[7:1], m_stage);
        end
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic direct(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s direct: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] tok, input logic d1, input logic emp,
                        input logic crc);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_token = tok; pkt_data1 = d1; pkt_empty = emp;
        pkt_crc_ok = crc;
        @(negedge clk);
        pkt_valid = 1'b0; pkt_crc_ok = 1'b1;
    endtask

    task automatic pulse_halt(input logic set);
        @(negedge clk);
        if (set) halt_set = 1'b1; else halt_clr = 1'b1;
        @(negedge clk);
        halt_set = 1'b0; halt_clr = 1'b0;
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        direct("R1", int'(hs_code), 0);
        direct("R1", int'(xfer_stage), 0);

        cur_req = "R10";
        send(2'd1, 1'b1, 1'b1, 1'b1);
        direct("R10", int'(hs_code), 0);

        cur_req = "R3";
        send(2'd0, 1'b0, 1'b0, 1'b1);
        direct("R3", int'(hs_code), 1);

        cur_req = "R4";
        fifo_en = 1'b0;
        send(2'd1, 1'b1, 1'b1, 1'b1);
        direct("R4", int'(hs_code), 2);
        fifo_en = 1'b1;
        send(2'd1, 1'b1, 1'b1, 1'b1);
        direct("R4", int'(hs_code), 1);

        cur_req = "R7";
        send(2'd3, 1'b0, 1'b1, 1'b1);
        direct("R7", int'(irq_tx_done), 1);
        send(2'd3, 1'b0, 1'b1, 1'b1);
        direct("R7", int'(irq_tx_done), 0);

        cur_req = "R2";
        send(2'd0, 1'b0, 1'b0, 1'b0);
        send(2'd1, 1'b1, 1'b1, 1'b0);
        direct("R2", int'(hs_code), 0);

        cur_req = "R6";
        pulse_halt(1'b1);
        direct("R6", int'(ep_halted), 1);
        cur_req = "R4";
        send(2'd1, 1'b1, 1'b1, 1'b1);
        direct("R4", int'(hs_code), 3);
        cur_req = "R5";
        pulse_halt(1'b0);
        send(2'd1, 1'b1, 1'b1, 1'b1);
        direct("R5", int'(hs_code), 3);
        send(2'd3, 1'b0, 1'b1, 1'b1);
        direct("R7", int'(irq_tx_done), 0);
        send(2'd2, 1'b1, 1'b1, 1'b1);
        direct("R5", int'(hs_code), 3);

        cur_req = "R3";
        send(2'd0, 1'b1, 1'b0, 1'b1);
        direct("R3", int'(hs_code), 0);
        send(2'd0, 1'b0, 1'b0, 1'b1);
        send(2'd1, 1'b1, 1'b1, 1'b1);
        direct("R3", int'(hs_code), 1);

        cur_req = "R6";
        @(negedge clk); stall_cmd = 1'b1; halt_set = 1'b1; halt_clr = 1'b1;
        @(negedge clk); halt_set = 1'b0; halt_clr = 1'b0;
        direct("R6", int'(ep_halted), 1);
        pulse_halt(1'b0);
        send(2'd1, 1'b1, 1'b1, 1'b1);
        direct("R6", int'(hs_code), 3);
        direct("R6", int'(ep_halted), 0);
        stall_cmd = 1'b0;

        cur_req = "R8";
        send(2'd0, 1'b0, 1'b0, 1'b1);
        send(2'd1, 1'b1, 1'b1, 1'b1);
        fifo_en = 1'b0;
        send(2'd2, 1'b1, 1'b1, 1'b1);
        direct("R8", int'(hs_code), 2);
        direct("R8", int'(xfer_stage), 2);
        fifo_en = 1'b1;
        send(2'd2, 1'b1, 1'b1, 1'b1);
        direct("R8", int'(irq_rx_done), 1);
        direct("R8", int'(xfer_stage), 0);
        cur_req = "R10";
        send(2'd2, 1'b1, 1'b1, 1'b1);
        direct("R10", int'(hs_code), 0);

        cur_req = "R8";
        send(2'd0, 1'b0, 1'b0, 1'b1);
        send(2'd2, 1'b0, 1'b1, 1'b1);
        direct("R8", int'(hs_code), 3);
        direct("R8", int'(irq_rx_done), 1);
        cur_req = "R5";
        send(2'd2, 1'b1, 1'b1, 1'b1);
        direct("R5", int'(hs_code), 3);

        cur_req = "R9";
        send(2'd0, 1'b0, 1'b0, 1'b1);
        send(2'd2, 1'b1, 1'b0, 1'b1);
        direct("R9", int'(hs_code), 1);
        direct("R9", int'(rx_wr_en), 0);

        cur_req = "R11";
        send(2'd0, 1'b0, 1'b0, 1'b1);
        fifo_en = 1'b0;
        send(2'd2, 1'b1, 1'b1, 1'b1);
        send(2'd1, 1'b1, 1'b1, 1'b1);
        direct("R11", int'(hs_code), 3);
        send(2'd2, 1'b1, 1'b1, 1'b1);
        direct("R11", int'(hs_code), 3);

        cur_req = "R8";
        fifo_en = 1'b1;
        send(2'd0, 1'b0, 1'b0, 1'b1);
        direct("R3", int'(xfer_stage), 1);
        pulse_halt(1'b1);
        send(2'd2, 1'b1, 1'b1, 1'b1);
        direct("R8", int'(hs_code), 1);
        pulse_halt(1'b0);

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule